// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard bookkeeper for an out-of-order floating-point back end with five execution units: one integer unit, two multipliers, one adder and one divider. Instructions arrive one per cycle from an in-order stream. Each carries an execution class, a destination register and two source registers. The block keeps a status record for each unit and a table that maps each register to the unit that will next write it.

Each instruction goes through four gated steps. Issue needs a free unit of the right class and no pending writer of the same destination. Operand read needs both sources free of pending writers. Execution is performed outside the block and ends with a done pulse from the unit. Write-back needs that no earlier instruction still wants the old value of the destination. Operands are always taken from the register file, and nothing is forwarded. The block only grants permission: it produces an issue acceptance, per-unit read grants and a single write-back grant per cycle.

Top module: `scoreboard_ctrl`

## Requirements
- R1: Class codes are 0 integer, 1 multiply, 2 add, 3 divide. Unit IDs are 1 integer, 2 first multiplier, 3 second multiplier, 4 adder and 5 divider, with 0 meaning none. Bit n of every unit vector belongs to unit ID n+1. An accepted instruction goes to a free unit of its class. A multiply goes to the lower-numbered free multiplier.
- R2: `iss_ready` stays low while every unit of the requested class is busy.
- R3: `iss_ready` stays low while any active instruction has the requested destination register.
- R4: A unit whose two sources have no pending writer gets its read grant in the cycle after issue. A unit gets exactly one read grant per instruction.
- R5: A source with a pending writer blocks the read grant. The grant comes in the cycle after that writer's write-back grant, never in the same cycle.
- R6: An `ex_done` pulse counts only for a busy unit that has already had its read grant. Pulses to idle units, or to units still waiting for operands, are ignored.
- R7: A finished unit is held off write-back while another active instruction that has not yet read its operands names the finished unit's destination as a ready source.
- R8: At most one write-back grant is given per cycle, to the lowest-numbered finished unit that has no conflict. `wb_reg` shows that unit's destination register.
- R9: A write-back frees its unit and its destination register. Both can be used by an instruction issued in the next cycle.
- R10: During reset and after it, no unit is busy, and no read or write-back grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 2 | Execution class of the offered instruction |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_ready | output | 1 | The offered instruction is accepted at this edge |
| iss_unit | output | 3 | ID of the accepting unit, 0 when not accepted |
| rd_grant | output | 5 | Per-unit permission to read operands this cycle |
| ex_done | input | 5 | Per-unit execution-finished pulse |
| wb_grant | output | 5 | One-hot write-back permission |
| wb_reg | output | REG_W | Register written by the granted unit |

## Verification
A wrong register-status entry shows up at the ports in the same cycle. An instruction naming that register either stalls on `iss_ready` when it should not, or is accepted when it should stall. A dependent unit also gets its `rd_grant` too early, or never gets it. A wrong per-unit ready flag or finished flag shows up within one cycle of the event that should have set it. The symptom is a read grant or write-back grant that is missing, early or out of priority order. The tests therefore check every grant vector cycle by cycle through RAW, WAR, WAW and structural conflicts. They also sweep all destination indices against a pending writer.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;
  localparam int CLS_W     = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } fu_class_e;

  // class served by the unit at vector position idx (unit ID idx+1)
  function automatic fu_class_e unit_class(input int idx);
    case (idx)
      0:       return CLS_INT;
      1, 2:    return CLS_MUL;
      3:       return CLS_ADD;
      default: return CLS_DIV;
    endcase
  endfunction

  // isolate the lowest set bit
  function automatic logic [NUM_UNITS-1:0] lowest_one(input logic [NUM_UNITS-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // vector position to unit ID, 0 when the vector is empty
  function automatic logic [UNIT_W-1:0] onehot_to_id(input logic [NUM_UNITS-1:0] v);
    logic [UNIT_W-1:0] id;
    id = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (v[i]) id = UNIT_W'(i + 1);
    return id;
  endfunction

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
(
  input  logic                 req,
  input  fu_class_e            cls,
  input  logic [NUM_UNITS-1:0] busy,
  input  logic                 dst_pending,
  output logic                 accept,
  output logic [NUM_UNITS-1:0] load_vec,
  output logic [UNIT_W-1:0]    unit_id_o
);

  logic [NUM_UNITS-1:0] cand;
  logic [NUM_UNITS-1:0] pick;

  // free units able to execute the requested class
  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++)
      cand[i] = !busy[i] && (unit_class(i) == cls);
  end

  assign pick      = lowest_one(cand);
  assign accept    = req && (|cand) && !dst_pending;
  assign load_vec  = accept ? pick : '0;
  assign unit_id_o = accept ? onehot_to_id(pick) : '0;

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int UNIT_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  fu_class_e         ld_op,
  input  logic [REG_W-1:0]  ld_fi,
  input  logic [REG_W-1:0]  ld_fj,
  input  logic [REG_W-1:0]  ld_fk,
  input  logic [UNIT_W-1:0] ld_qj,
  input  logic [UNIT_W-1:0] ld_qk,
  input  logic              rd_gnt,
  input  logic              ex_done,
  input  logic              wb_gnt,
  input  logic              wb_valid,
  input  logic [UNIT_W-1:0] wb_unit,
  output logic              busy,
  output logic              rd_req,
  output logic              done,
  output logic              rj,
  output logic              rk,
  output logic [REG_W-1:0]  fi,
  output logic [REG_W-1:0]  fj,
  output logic [REG_W-1:0]  fk
);

  fu_class_e         op_q;
  logic              read_q;
  logic [UNIT_W-1:0] qj_q;
  logic [UNIT_W-1:0] qk_q;

  // a producer named by qj/qk is broadcasting its result this cycle
  logic j_wake, k_wake;
  assign j_wake = wb_valid && (qj_q != '0) && (qj_q == wb_unit);
  assign k_wake = wb_valid && (qk_q != '0) && (qk_q == wb_unit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      read_q <= 1'b0;
      done   <= 1'b0;
      op_q   <= CLS_INT;
      fi     <= '0;
      fj     <= '0;
      fk     <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
      rj     <= 1'b0;
      rk     <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      read_q <= 1'b0;
      done   <= 1'b0;
      op_q   <= ld_op;
      fi     <= ld_fi;
      fj     <= ld_fj;
      fk     <= ld_fk;
      qj_q   <= ld_qj;
      qk_q   <= ld_qk;
      rj     <= (ld_qj == '0);
      rk     <= (ld_qk == '0);
    end else if (wb_gnt) begin
      busy   <= 1'b0;
      read_q <= 1'b0;
      done   <= 1'b0;
      rj     <= 1'b0;
      rk     <= 1'b0;
      qj_q   <= '0;
      qk_q   <= '0;
    end else begin
      if (rd_gnt) begin
        read_q <= 1'b1;
        rj     <= 1'b0;
        rk     <= 1'b0;
      end else begin
        if (j_wake) begin
          rj   <= 1'b1;
          qj_q <= '0;
        end
        if (k_wake) begin
          rk   <= 1'b1;
          qk_q <= '0;
        end
      end
      if (ex_done && busy && read_q)
        done <= 1'b1;
    end
  end

  assign rd_req = busy && !read_q && rj && rk;

  // R1
  op_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (op_q == unit_class(UNIT_IDX)));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_q |-> !rd_gnt);

  // R6
  early_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_done && !read_q && !load) |=> !done);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb_gnt) |=> busy);

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
  import sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] req,
  output logic [NUM_UNITS-1:0] grant
);

  assign grant = lowest_one(req);

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sb_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [CLS_W-1:0]     iss_class,
  input  logic [REG_W-1:0]     iss_dst,
  input  logic [REG_W-1:0]     iss_src_a,
  input  logic [REG_W-1:0]     iss_src_b,
  output logic                 iss_ready,
  output logic [UNIT_W-1:0]    iss_unit,
  output logic [NUM_UNITS-1:0] rd_grant,
  input  logic [NUM_UNITS-1:0] ex_done,
  output logic [NUM_UNITS-1:0] wb_grant,
  output logic [REG_W-1:0]     wb_reg
);

  localparam int NUM_REGS = 1 << REG_W;

  // register result status: unit that will write each register, 0 = none
  logic [UNIT_W-1:0] res_stat [NUM_REGS];

  logic [NUM_UNITS-1:0] busy_v, rd_req_v, done_v, rj_v, rk_v, load_v, wb_req_v;
  logic [REG_W-1:0]     fi_v [NUM_UNITS];
  logic [REG_W-1:0]     fj_v [NUM_UNITS];
  logic [REG_W-1:0]     fk_v [NUM_UNITS];

  logic              wb_valid;
  logic [UNIT_W-1:0] wb_unit;
  logic              dst_pending;
  logic [UNIT_W-1:0] qj_new, qk_new;
  fu_class_e         cls_in;

  assign cls_in      = fu_class_e'(iss_class);
  assign dst_pending = (res_stat[iss_dst] != '0);

  // a producer writing back this cycle counts as already done for a newcomer
  assign qj_new = (wb_valid && res_stat[iss_src_a] == wb_unit) ? '0 : res_stat[iss_src_a];
  assign qk_new = (wb_valid && res_stat[iss_src_b] == wb_unit) ? '0 : res_stat[iss_src_b];

  sb_issue_sel u_issue (
    .req        (iss_valid),
    .cls        (cls_in),
    .busy       (busy_v),
    .dst_pending(dst_pending),
    .accept     (iss_ready),
    .load_vec   (load_v),
    .unit_id_o  (iss_unit)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    sb_fu_entry #(
      .REG_W   (REG_W),
      .UNIT_IDX(g)
    ) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_v[g]),
      .ld_op   (cls_in),
      .ld_fi   (iss_dst),
      .ld_fj   (iss_src_a),
      .ld_fk   (iss_src_b),
      .ld_qj   (qj_new),
      .ld_qk   (qk_new),
      .rd_gnt  (rd_grant[g]),
      .ex_done (ex_done[g]),
      .wb_gnt  (wb_grant[g]),
      .wb_valid(wb_valid),
      .wb_unit (wb_unit),
      .busy    (busy_v[g]),
      .rd_req  (rd_req_v[g]),
      .done    (done_v[g]),
      .rj      (rj_v[g]),
      .rk      (rk_v[g]),
      .fi      (fi_v[g]),
      .fj      (fj_v[g]),
      .fk      (fk_v[g])
    );

    // R5
    rd_wb_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_grant[g] && wb_valid) |-> (fj_v[g] != wb_reg && fk_v[g] != wb_reg));
  end

  // operand reads are not limited in number
  assign rd_grant = rd_req_v;

  // WAR: an unread, ready source equal to a finished unit's destination
  always_comb begin
    for (int w = 0; w < NUM_UNITS; w++) begin
      logic hit;
      hit = 1'b0;
      for (int e = 0; e < NUM_UNITS; e++) begin
        if (e != w && busy_v[e] &&
            ((rj_v[e] && fj_v[e] == fi_v[w]) || (rk_v[e] && fk_v[e] == fi_v[w])))
          hit = 1'b1;
      end
      wb_req_v[w] = done_v[w] && !hit;
    end
  end

  sb_wb_arb u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (wb_req_v),
    .grant(wb_grant)
  );

  assign wb_valid = |wb_grant;
  assign wb_unit  = onehot_to_id(wb_grant);

  always_comb begin
    wb_reg = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (wb_grant[i]) wb_reg = fi_v[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) res_stat[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (iss_ready && iss_dst == REG_W'(r))
          res_stat[r] <= iss_unit;
        else if (wb_valid && wb_reg == REG_W'(r))
          res_stat[r] <= '0;
      end
    end
  end

  // R3
  waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> (res_stat[iss_dst] == '0));

  // R9
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (res_stat[$past(wb_reg)] == '0));

endmodule

// File: tb/scoreboard_ctrl_tb.sv
`timescale 1ns/1ps
module scoreboard_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid;
  logic [1:0] iss_class;
  logic [3:0] iss_dst, iss_src_a, iss_src_b;
  logic       iss_ready;
  logic [2:0] iss_unit;
  logic [4:0] rd_grant, ex_done, wb_grant;
  logic [3:0] wb_reg;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  scoreboard_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_class(iss_class), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_ready(iss_ready), .iss_unit(iss_unit),
    .rd_grant(rd_grant), .ex_done(ex_done),
    .wb_grant(wb_grant), .wb_reg(wb_reg)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after the edge, check settled outputs before the next edge
  task automatic cyc(input logic v, input logic [1:0] c, input logic [3:0] d,
                     input logic [3:0] a, input logic [3:0] b, input logic [4:0] dn,
                     input logic er, input logic [2:0] eu, input logic [4:0] erd,
                     input logic [4:0] ewb, input logic [3:0] ewr, input string tag);
    @(posedge clk); #2;
    iss_valid = v; iss_class = c; iss_dst = d; iss_src_a = a; iss_src_b = b; ex_done = dn;
    #1;
    chk(tag, "iss_ready", int'(iss_ready), int'(er));
    if (er) chk(tag, "iss_unit", int'(iss_unit), int'(eu));
    chk(tag, "rd_grant", int'(rd_grant), int'(erd));
    chk(tag, "wb_grant", int'(wb_grant), int'(ewb));
    if (ewb != 0) chk(tag, "wb_reg", int'(wb_reg), int'(ewr));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; iss_valid = 0; iss_class = 0; iss_dst = 0;
    iss_src_a = 0; iss_src_b = 0; ex_done = 5'b11111;
    repeat (2) @(posedge clk);
    #3;
    // R10 reset state
    chk("R10", "iss_ready", int'(iss_ready), 0);
    chk("R10", "rd_grant", int'(rd_grant), 0);
    chk("R10", "wb_grant", int'(wb_grant), 0);
    ex_done = 0;
    rst_n = 1'b1;
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00000,0, "R10");

    // Test A: class mapping, structural stalls, priority drain (R1 R2 R4 R8 R9)
    cyc(1,0,1,0,0,5'b00000, 1,1,5'b00000,5'b00000,0, "R1");
    cyc(1,1,2,0,0,5'b00000, 1,2,5'b00001,5'b00000,0, "R1");
    cyc(1,1,3,0,0,5'b00000, 1,3,5'b00010,5'b00000,0, "R1");
    cyc(1,1,4,0,0,5'b00000, 0,0,5'b00100,5'b00000,0, "R2");
    cyc(1,2,4,0,0,5'b00000, 1,4,5'b00000,5'b00000,0, "R1");
    cyc(1,2,5,0,0,5'b00000, 0,0,5'b01000,5'b00000,0, "R2");
    cyc(1,3,5,0,0,5'b00000, 1,5,5'b00000,5'b00000,0, "R1");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b10000,5'b00000,0, "R4");
    cyc(0,0,0,0,0,5'b11111, 0,0,5'b00000,5'b00000,0, "R6");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00001,1, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00010,2, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00100,3, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b01000,4, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b10000,5, "R8");
    cyc(1,1,2,0,0,5'b00000, 1,2,5'b00000,5'b00000,0, "R9");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00010,5'b00000,0, "R4");
    cyc(0,0,0,0,0,5'b00010, 0,0,5'b00000,5'b00000,0, "R6");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00010,2, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00000,0, "R10");

    // Test B: WAW sweep over every destination index (R3), idle done pulses (R6)
    cyc(1,0,7,0,0,5'b00000, 1,1,5'b00000,5'b00000,0, "R1");
    @(posedge clk); #2;
    iss_valid = 1; iss_class = 2; iss_src_a = 0; iss_src_b = 0; ex_done = 0;
    for (int r = 0; r < 16; r++) begin
      iss_dst = 4'(r);
      #0.2;
      chk("R3", "iss_ready", int'(iss_ready), (r != 7) ? 1 : 0);
      if (r != 7) chk("R3", "iss_unit", int'(iss_unit), 4);
    end
    iss_valid = 0;
    #0.2;
    chk("R4", "rd_grant", int'(rd_grant), 1);
    cyc(0,0,0,0,0,5'b00011, 0,0,5'b00000,5'b00000,0, "R6");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00001,7, "R6");
    cyc(1,2,7,0,0,5'b00000, 1,4,5'b00000,5'b00000,0, "R9");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b01000,5'b00000,0, "R4");
    cyc(0,0,0,0,0,5'b01000, 0,0,5'b00000,5'b00000,0, "R6");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b01000,7, "R8");

    // Test C: RAW wait, no read in the write-back cycle, early done ignored (R5 R6)
    cyc(1,1,2,0,0,5'b00000, 1,2,5'b00000,5'b00000,0, "R1");
    cyc(1,2,6,2,0,5'b00000, 1,4,5'b00010,5'b00000,0, "R4");
    cyc(0,0,0,0,0,5'b01010, 0,0,5'b00000,5'b00000,0, "R5");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00010,2, "R5");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b01000,5'b00000,0, "R6");
    cyc(0,0,0,0,0,5'b01000, 0,0,5'b00000,5'b00000,0, "R6");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b01000,6, "R5");

    // Test D: WAR hold-off until the earlier reader consumes the old value (R7)
    cyc(1,1,4,0,0,5'b00000, 1,2,5'b00000,5'b00000,0, "R1");
    cyc(1,3,10,3,4,5'b00000, 1,5,5'b00010,5'b00000,0, "R4");
    cyc(1,2,3,0,0,5'b00000, 1,4,5'b00000,5'b00000,0, "R5");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b01000,5'b00000,0, "R4");
    cyc(0,0,0,0,0,5'b01000, 0,0,5'b00000,5'b00000,0, "R7");
    cyc(0,0,0,0,0,5'b00010, 0,0,5'b00000,5'b00000,0, "R7");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00010,4, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b10000,5'b00000,0, "R7");
    cyc(0,0,0,0,0,5'b10000, 0,0,5'b00000,5'b01000,3, "R7");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b10000,10, "R8");
    cyc(0,0,0,0,0,5'b00000, 0,0,5'b00000,5'b00000,0, "R10");

    finish_run();
  end

endmodule